// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block turns one shared active-low control pin into enable and power gating for a bank of eight clock outputs. A configuration bit gives the pin one of two meanings. In enable mode, pulling the pin low turns off only the outputs chosen by an 8-bit mask, and the other outputs keep toggling. In power-down mode, pulling the pin low turns off every output and drives power-down to every PLL. The pin passes through a two-stage synchronizer in the control clock domain before it is used.

Each output's enable is passed through two flops clocked on the falling edge of that output's own clock. An enable can therefore change only while its clock is low, and no shortened high pulse appears. Output 3 takes its source from either the reference clock or the first PLL's divided output, chosen by a configuration bit that the block registers and presents as a mux select. Output 7 is a duplicate of output 3 and always shares its enable. After reset, and after every exit from power-down, the outputs stay off until every PLL reports lock.

Top module: `clk_oe_pd_ctrl`

## Requirements
- R1: The pin is synchronized through two flops. In power-down mode, a low pin raises `pll_pd` right after the third rising `clk` edge that follows the pin's fall, and not before that edge.
- R2: In power-down mode (`cfg_pd_mode`=1) with the pin low, every bit of `pll_pd` is 1 and every bit of `clk_en` settles to 0.
- R3: In enable mode (`cfg_pd_mode`=0) with the pin low, each output whose mask bit is 1 has `clk_en` 0, each output whose mask bit is 0 has `clk_en` 1, and `pll_pd` stays 0.
- R4: With the pin high and all lock inputs high, every bit of `clk_en` settles to 1 and `pll_pd` is 0, in either mode.
- R5: After reset, and after leaving power-down, `clk_en` stays all 0 until every bit of `pll_lock` is 1.
- R6: A bit of `clk_en` changes only while the matching bit of `out_clk` is low, and only at that clock's falling edges.
- R7: `src_sel_pll` equals `cfg_src_pll` one `clk` cycle later. A value of 1 selects the first PLL's divided output for output 3, and 0 selects the reference clock.
- R8: `clk_en[7]` always equals `clk_en[3]`. In enable mode, mask bit 3 or mask bit 7 turns off both outputs.
- R9: While `rst` is high, `clk_en`, `pll_pd` and `src_sel_pll` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin_n | input | 1 | Shared asynchronous active-low control pin |
| cfg_pd_mode | input | 1 | 1: pin means power-down, 0: pin means output enable |
| cfg_src_pll | input | 1 | Source choice for output 3 (1 = PLL1 divided, 0 = reference) |
| cfg_oe_mask | input | 8 | Outputs that the enable function turns off |
| pll_lock | input | 4 | Lock indication from each PLL, in the `clk` domain |
| out_clk | input | 8 | Each output's own clock; bit 7 is a copy of bit 3 |
| clk_en | output | 8 | Enable for each output, changed only in its clock's low phase |
| pll_pd | output | 4 | Power-down to each PLL |
| src_sel_pll | output | 1 | Registered mux select for output 3 and its duplicate |

## Verification
Random draws of mode, pin level, mask and source bit separate three cases. Enable mode with the pin low must disturb only the masked outputs. Power-down mode with the pin low must turn off everything. A high pin must restore everything. Directed sequences cover the pin-to-`pll_pd` delay edge by edge and hold one lock low while leaving power-down, which shows that the lock gate blocks the restart. Masks with only bit 3 or only bit 7 set show that the duplicate pair is merged. A monitor on every enable bit flags any change made while that output's clock is high.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    // Phase of the shared control machine
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,   // outputs follow enable-mode request
        PH_DOWN = 2'd1,   // PLLs powered down, all outputs off
        PH_WAKE = 2'd2    // waiting for every PLL lock before restart
    } phase_t;

    // Decoded meaning of the synchronized pin under the current mode
    typedef struct packed {
        logic down_req;   // power-down requested
        logic oe_off;     // masked outputs requested off
    } pin_req_t;

    function automatic pin_req_t decode_pin(logic pd_mode, logic pin_low);
        pin_req_t r;
        r.down_req = pd_mode & pin_low;
        r.oe_off   = ~pd_mode & pin_low;
        return r;
    endfunction

    function automatic phase_t next_phase(phase_t cur, logic down_req, logic locked);
        phase_t n;
        case (cur)
            PH_RUN:  n = down_req ? PH_DOWN : PH_RUN;
            PH_DOWN: n = down_req ? PH_DOWN : PH_WAKE;
            PH_WAKE: n = down_req ? PH_DOWN : (locked ? PH_RUN : PH_WAKE);
            default: n = PH_WAKE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/clk_oe_pin_sync.sv
`timescale 1ns/1ps
module clk_oe_pin_sync #(
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/clk_oe_ctrl.sv
`timescale 1ns/1ps
module clk_oe_ctrl
    import clkgate_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int NUM_PLL = 4,
    parameter int SEL_IDX = 3,
    parameter int DUP_IDX = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_low,
    input  logic               pd_mode,
    input  logic [NUM_OUT-1:0] oe_mask,
    input  logic [NUM_PLL-1:0] lock,
    output logic [NUM_OUT-1:0] req_q,
    output logic [NUM_PLL-1:0] pll_down
);
    localparam logic [NUM_OUT-1:0] ALL_ON = {NUM_OUT{1'b1}};

    phase_t             phase_q;
    pin_req_t           pr;
    logic [NUM_OUT-1:0] mask_eff;
    logic               pair_off;
    logic               all_locked;

    assign pr         = decode_pin(pd_mode, pin_low);
    assign all_locked = &lock;
    assign pair_off   = oe_mask[SEL_IDX] | oe_mask[DUP_IDX];

    // The selectable output and its duplicate share one mask decision
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_mask
        if (i == SEL_IDX || i == DUP_IDX) begin : g_pair
            assign mask_eff[i] = pair_off;
        end else begin : g_single
            assign mask_eff[i] = oe_mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_WAKE;
            req_q   <= '0;
        end else begin
            phase_q <= next_phase(phase_q, pr.down_req, all_locked);
            if (phase_q == PH_RUN) begin
                req_q <= pr.oe_off ? ~mask_eff : ALL_ON;
            end else begin
                req_q <= '0;
            end
        end
    end

    assign pll_down = {NUM_PLL{phase_q == PH_DOWN}};
endmodule

// File: rtl/clk_oe_gate.sv
`timescale 1ns/1ps
module clk_oe_gate #(
    parameter int STAGES = 2
) (
    input  logic out_clk,
    input  logic rst,
    input  logic req,
    output logic en
);
    logic [STAGES-1:0] stg;

    // Falling-edge flops: the enable only moves during the low phase
    always_ff @(negedge out_clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], req};
        end
    end

    assign en = stg[STAGES-1];
endmodule

// File: rtl/clk_oe_pd_ctrl.sv
`timescale 1ns/1ps
module clk_oe_pd_ctrl #(
    parameter int NUM_OUT   = 8,
    parameter int NUM_PLL   = 4,
    parameter int SEL_IDX   = 3,
    parameter int DUP_IDX   = 7,
    parameter int PIN_SYNC  = 2,
    parameter int GATE_SYNC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_pin_n,
    input  logic               cfg_pd_mode,
    input  logic               cfg_src_pll,
    input  logic [NUM_OUT-1:0] cfg_oe_mask,
    input  logic [NUM_PLL-1:0] pll_lock,
    input  logic [NUM_OUT-1:0] out_clk,
    output logic [NUM_OUT-1:0] clk_en,
    output logic [NUM_PLL-1:0] pll_pd,
    output logic               src_sel_pll
);
    logic               pin_n_s;
    logic [NUM_OUT-1:0] req_vec;

    clk_oe_pin_sync #(
        .STAGES  (PIN_SYNC),
        .RST_VAL (1'b1)
    ) pin_sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (ctl_pin_n),
        .q_sync  (pin_n_s)
    );

    clk_oe_ctrl #(
        .NUM_OUT (NUM_OUT),
        .NUM_PLL (NUM_PLL),
        .SEL_IDX (SEL_IDX),
        .DUP_IDX (DUP_IDX)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .pin_low  (~pin_n_s),
        .pd_mode  (cfg_pd_mode),
        .oe_mask  (cfg_oe_mask),
        .lock     (pll_lock),
        .req_q    (req_vec),
        .pll_down (pll_pd)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
        clk_oe_gate #(
            .STAGES (GATE_SYNC)
        ) gate_i (
            .out_clk (out_clk[i]),
            .rst     (rst),
            .req     (req_vec[i]),
            .en      (clk_en[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_sel_pll <= 1'b0;
        end else begin
            src_sel_pll <= cfg_src_pll;
        end
    end
endmodule

// File: rtl/clk_oe_pd_chk.sv
`timescale 1ns/1ps
module clk_oe_pd_chk #(
    parameter int NUM_OUT = 8,
    parameter int NUM_PLL = 4,
    parameter int SEL_IDX = 3,
    parameter int DUP_IDX = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               ctl_pin_n,
    input logic               cfg_pd_mode,
    input logic               cfg_src_pll,
    input logic [NUM_PLL-1:0] pll_pd,
    input logic               src_sel_pll,
    input logic [NUM_OUT-1:0] req_vec
);
    AST_PD_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_pd[0]) |-> (!$past(ctl_pin_n, 3) && $past(cfg_pd_mode))); // R1

    AST_PD_ALL_PLLS: assert property (@(posedge clk) disable iff (rst)
        (pll_pd == '0) || (&pll_pd)); // R2

    AST_PD_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
        (pll_pd[0] && $past(pll_pd[0])) |-> (req_vec == '0)); // R2

    AST_OE_NO_PD: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_pd_mode) |-> (pll_pd == '0)); // R3

    AST_WAKE_HELD: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_pd[0]) |=> (req_vec == '0)); // R5

    AST_SRC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_src_pll) == src_sel_pll); // R7

    AST_DUP_MATCH: assert property (@(posedge clk) disable iff (rst)
        req_vec[SEL_IDX] == req_vec[DUP_IDX]); // R8
endmodule

bind clk_oe_pd_ctrl clk_oe_pd_chk #(
    .NUM_OUT (NUM_OUT),
    .NUM_PLL (NUM_PLL),
    .SEL_IDX (SEL_IDX),
    .DUP_IDX (DUP_IDX)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ctl_pin_n   (ctl_pin_n),
    .cfg_pd_mode (cfg_pd_mode),
    .cfg_src_pll (cfg_src_pll),
    .pll_pd      (pll_pd),
    .src_sel_pll (src_sel_pll),
    .req_vec     (req_vec)
);

// File: tb/clk_oe_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_oe_pd_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_pin_n = 1'b1;
    logic       cfg_pd_mode = 1'b0;
    logic       cfg_src_pll = 1'b0;
    logic [7:0] cfg_oe_mask = 8'h00;
    logic [3:0] pll_lock = 4'h0;
    logic [6:0] oc = 7'h0;
    logic [7:0] out_clk;
    logic [7:0] clk_en;
    logic [3:0] pll_pd;
    logic       src_sel_pll;

    int errors = 0;
    int checks = 0;
    int glitches = 0;
    int en_edges = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    for (genvar g = 0; g < 7; g++) begin : g_oclk
        initial begin
            #(1 + g);
            forever #(3 + g) oc[g] = ~oc[g];
        end
    end
    assign out_clk = {oc[3], oc[6:0]};

    clk_oe_pd_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .ctl_pin_n   (ctl_pin_n),
        .cfg_pd_mode (cfg_pd_mode),
        .cfg_src_pll (cfg_src_pll),
        .cfg_oe_mask (cfg_oe_mask),
        .pll_lock    (pll_lock),
        .out_clk     (out_clk),
        .clk_en      (clk_en),
        .pll_pd      (pll_pd),
        .src_sel_pll (src_sel_pll)
    );

    // R6 monitor: an enable bit may only move while its clock is low
    for (genvar g = 0; g < 8; g++) begin : g_mon
        always @(clk_en[g]) begin
            if (!rst && $time > 0) begin
                en_edges++;
                if (out_clk[g] === 1'b1) glitches++;
            end
        end
    end

    function automatic logic [7:0] merge_mask(logic [7:0] m);
        logic [7:0] r = m;
        if (m[3] | m[7]) r = r | 8'h88;
        return r;
    endfunction

    function automatic logic [7:0] exp_en(logic pd, logic pin_n, logic [7:0] m);
        if (pin_n) return 8'hFF;
        if (pd) return 8'h00;
        return ~merge_mask(m);
    endfunction

    function automatic logic [3:0] exp_pd(logic pd, logic pin_n);
        return (pd && !pin_n) ? 4'hF : 4'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (12) @(negedge clk);
        // R9: reset state
        check("R9 clk_en in reset", 32'(clk_en), 32'h00);
        check("R9 pll_pd in reset", 32'(pll_pd), 32'h0);
        check("R9 src_sel in reset", 32'(src_sel_pll), 32'h0);
        rst = 1'b0;
        settle();
        // R5: no lock after reset keeps outputs off
        check("R5 no lock after reset", 32'(clk_en), 32'h00);
        pll_lock = 4'hF;
        settle();
        check("R4 pin high, locked", 32'(clk_en), 32'hFF);
        check("R4 pll_pd low", 32'(pll_pd), 32'h0);

        // R7: select follows one cycle later
        cfg_src_pll = 1'b1;
        @(negedge clk);
        check("R7 src select to PLL", 32'(src_sel_pll), 32'h1);
        cfg_src_pll = 1'b0;
        @(negedge clk);
        check("R7 src select to reference", 32'(src_sel_pll), 32'h0);

        // R1: pin-to-power-down delay
        cfg_pd_mode = 1'b1;
        @(negedge clk);
        ctl_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pll_pd before third edge", 32'(pll_pd), 32'h0);
        @(negedge clk);
        check("R1 pll_pd after third edge", 32'(pll_pd), 32'hF);
        settle();
        check("R2 all outputs off", 32'(clk_en), 32'h00);

        // R5: leave power-down with one PLL unlocked
        pll_lock = 4'b1011;
        ctl_pin_n = 1'b1;
        settle();
        check("R5 pll_pd released", 32'(pll_pd), 32'h0);
        check("R5 outputs held until lock", 32'(clk_en), 32'h00);
        pll_lock = 4'hF;
        settle();
        check("R5 outputs after lock", 32'(clk_en), 32'hFF);

        // R8: duplicate pair shares mask decision
        cfg_pd_mode = 1'b0;
        cfg_oe_mask = 8'h80;
        ctl_pin_n = 1'b0;
        settle();
        check("R8 mask bit 7 only", 32'(clk_en), 32'h77);
        cfg_oe_mask = 8'h08;
        settle();
        check("R8 mask bit 3 only", 32'(clk_en), 32'h77);
        check("R3 no PLL power-down in enable mode", 32'(pll_pd), 32'h0);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            logic       pd = 1'($urandom);
            logic       pn = 1'($urandom);
            logic [7:0] m  = 8'($urandom);
            logic       s  = 1'($urandom);
            cfg_pd_mode = pd;
            ctl_pin_n   = pn;
            cfg_oe_mask = m;
            cfg_src_pll = s;
            settle();
            if (pn)       check("R4 random clk_en", 32'(clk_en), 32'(exp_en(pd, pn, m)));
            else if (pd)  check("R2 random clk_en", 32'(clk_en), 32'(exp_en(pd, pn, m)));
            else          check("R3 random clk_en", 32'(clk_en), 32'(exp_en(pd, pn, m)));
            check("R2 random pll_pd", 32'(pll_pd), 32'(exp_pd(pd, pn)));
            check("R7 random src select", 32'(src_sel_pll), 32'(s));
            check("R8 random pair match", 32'(clk_en[7]), 32'(clk_en[3]));
        end

        check("R6 enable moved while clock high", 32'(glitches), 32'h0);
        check("R6 enable edges observed", 32'(en_edges > 0), 32'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule